// File: doc/BRIEF.md
# Ethernet MAC interrupt status unit

This block gathers event indications from the receive and transmit sides of an Ethernet MAC into a five-bit raw interrupt status register. A per-source enable register gates each status bit, and two more enables gate a PHY interrupt line and a management-interface interrupt line. The gated terms are ORed into one registered interrupt output towards the processor.

Software uses a small register bus. A read at byte offset 0x000 returns the raw status. A write at 0x000 acknowledges: every 1 in the data clears the matching status bit. Offset 0x004 holds the enable register, which can be read and written.

The block also screens queued transmit frames by their length field. A frame that is too long is dropped and raises the transmit error. A retry count from the backoff logic raises the same error once it passes its limit. Four receive fault conditions are merged into one receive error. Acknowledging the transmit error also sends a one-cycle reset pulse to the transmit FIFO write pointer.

Top module: `emac_irq_unit`

## Requirements
- R1: Status bit positions at offset 0x000 are fixed: bit 0 packet received, bit 1 transmit error, bit 2 transmit FIFO drained, bit 3 receive overrun, bit 4 receive error. A source event sets its bit on the clock edge that samples the event, so the bit reads back 1 in the next cycle.
- R2: After reset the status reads 0x00 and the enable register reads 0x7F.
- R3: A bus write to offset 0x000 clears each status bit whose data bit is 1. Status bits whose data bit is 0 are unchanged.
- R4: When a set event and an acknowledge of the same bit occur in the same cycle, the bit ends up set.
- R5: A write to offset 0x000 with data bit 1 set makes `fifo_wptr_rst` high for exactly the next cycle. Any other write leaves it low.
- R6: A queued frame whose length field is at most 2032 is passed on (`txq_send`=1, `txq_drop`=0) in the same cycle. A length of 2033 or more is dropped (`txq_drop`=1, `txq_send`=0) and sets status bit 1. The two outputs are never high together.
- R7: A backoff retry count above 16 that is presented with `bo_retry_valid` sets status bit 1. A count of 16 or less does not set it.
- R8: Status bit 4 is set by an alignment fault, an FCS fault or a length/type mismatch. It is also set by a PHY symbol error, but only while `rx_in_frame` and `rx_speed_100` are both high.
- R9: `irq` is a register. One cycle after a given state it equals: OR over bits 0..4 of (status AND enable), OR (`phy_irq` AND enable bit 6), OR (`mgmt_irq` AND enable bit 5).
- R10: A write to offset 0x004 loads the enable register from data bits 6..0. All other bits of both registers read 0, and reads at any other offset return 0.
- R11: Status bit 0 is set again on every cycle that `rx_pkt_avail` is high, so an acknowledge does not clear it while a packet is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe when selected |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rx_pkt_avail | input | 1 | Level: at least one complete packet is stored in the receive FIFO |
| tx_drained | input | 1 | Pulse: a packet was sent and the transmit FIFO is empty |
| rx_overrun | input | 1 | Pulse: receive FIFO overrun |
| rx_in_frame | input | 1 | Level: a frame is being received |
| rx_speed_100 | input | 1 | Level: link runs at 100 Mb/s |
| rx_sym_err | input | 1 | Pulse: PHY signalled a receive symbol error |
| rx_align_err | input | 1 | Pulse: frame was not a whole number of bytes |
| rx_fcs_err | input | 1 | Pulse: FCS check failed |
| rx_lenfld_err | input | 1 | Pulse: length/type field does not match the data size |
| txq_len_valid | input | 1 | Length field of the queued transmit frame is valid |
| txq_len | input | 16 | Length field of the queued transmit frame |
| txq_send | output | 1 | Queued frame accepted for transmission |
| txq_drop | output | 1 | Queued frame discarded because it is too long |
| bo_retry_valid | input | 1 | Retry count from the backoff logic is valid |
| bo_retry_cnt | input | 5 | Retransmission attempt count |
| phy_irq | input | 1 | Level interrupt from the PHY |
| mgmt_irq | input | 1 | Level interrupt from the management interface |
| irq | output | 1 | Registered combined interrupt |
| fifo_wptr_rst | output | 1 | One-cycle reset pulse for the transmit FIFO write pointer |

## Verification
The assertions assume one bus access at most per cycle and a synchronous, glitch-free `bus_wdata`. They also assume that event pulses are sampled only on the edge where they are driven, so an event held high for several cycles counts as several events. The stimulus drives every input right after the falling edge and returns each pulse input to 0 after one cycle. Level inputs such as `rx_pkt_avail`, `phy_irq` and the receive qualifiers change only between whole cycles. Acknowledge writes are deliberately placed in the same cycle as set events to exercise the set-wins rule.

// File: rtl/emac_irq_pkg.sv
package emac_irq_pkg;
  localparam int NSRC      = 5;
  localparam int NMASK     = 7;
  localparam int B_RXPKT   = 0;
  localparam int B_TXERR   = 1;
  localparam int B_TXEMP   = 2;
  localparam int B_RXOVF   = 3;
  localparam int B_RXERR   = 4;
  localparam int B_MGMTEN  = 5;
  localparam int B_PHYEN   = 6;

  typedef struct packed {
    logic rx_err;
    logic rx_ovf;
    logic tx_emp;
    logic tx_err;
    logic rx_pkt;
  } src_t;

  function automatic logic above_limit(input logic [31:0] value, input logic [31:0] limit);
    return value > limit;
  endfunction

  function automatic logic sym_err_counts(input logic in_frame, input logic fast, input logic sym);
    return sym & in_frame & fast;
  endfunction
endpackage

// File: rtl/emac_tx_len_check.sv
module emac_tx_len_check
  import emac_irq_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int MAX_LEN   = 2032,
  parameter int RETRY_W   = 5,
  parameter int MAX_RETRY = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               len_valid,
  input  logic [LEN_W-1:0]   len,
  input  logic               retry_valid,
  input  logic [RETRY_W-1:0] retry_cnt,
  output logic               send,
  output logic               drop,
  output logic               tx_err_evt
);
  localparam logic [31:0] LEN_LIM   = 32'(MAX_LEN);
  localparam logic [31:0] RETRY_LIM = 32'(MAX_RETRY);

  logic len_big_w;
  logic retry_over_w;

  always_comb begin
    len_big_w    = above_limit(32'(len), LEN_LIM);
    retry_over_w = retry_valid & above_limit(32'(retry_cnt), RETRY_LIM);
    send         = len_valid & ~len_big_w;
    drop         = len_valid & len_big_w;
    tx_err_evt   = drop | retry_over_w;
  end

  // R6
  send_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(send && drop));

  // R6
  drop_raises_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> tx_err_evt);
endmodule

// File: rtl/emac_rx_err_merge.sv
module emac_rx_err_merge
  import emac_irq_pkg::*;
(
  input  logic in_frame,
  input  logic speed_100,
  input  logic sym_err,
  input  logic align_err,
  input  logic fcs_err,
  input  logic lenfld_err,
  output logic rx_err_evt
);
  always_comb begin
    rx_err_evt = sym_err_counts(in_frame, speed_100, sym_err)
               | align_err | fcs_err | lenfld_err;
  end
endmodule

// File: rtl/emac_irq_regs.sv
module emac_irq_regs
  import emac_irq_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int STAT_OFS = 0,
  parameter int MASK_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  src_t              set_vec,
  input  logic              phy_irq,
  input  logic              mgmt_irq,
  output logic              irq,
  output logic              wptr_rst
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_OFS);
  localparam logic [NMASK-1:0]  MASK_RST = '1;

  logic [NSRC-1:0]  stat_q;
  logic [NSRC-1:0]  set_w;
  logic [NSRC-1:0]  clr_w;
  logic [NSRC-1:0]  stat_d;
  logic [NSRC-1:0]  pend_w;
  logic [NMASK-1:0] mask_q;
  logic             ack_wr;
  logic             mask_wr;
  logic             ext_w;
  logic             irq_q;
  logic             wptr_q;

  assign set_w   = set_vec;
  assign ack_wr  = bus_sel & bus_wr & (bus_addr == A_STAT);
  assign mask_wr = bus_sel & bus_wr & (bus_addr == A_MASK);
  assign clr_w   = ack_wr ? bus_wdata[NSRC-1:0] : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    assign stat_d[i] = set_w[i] | (stat_q[i] & ~clr_w[i]);
    assign pend_w[i] = stat_q[i] & mask_q[i];
  end

  assign ext_w = (phy_irq & mask_q[B_PHYEN]) | (mgmt_irq & mask_q[B_MGMTEN]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= MASK_RST;
      irq_q  <= 1'b0;
      wptr_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (mask_wr) mask_q <= bus_wdata[NMASK-1:0];
      irq_q  <= (|pend_w) | ext_w;
      wptr_q <= ack_wr & bus_wdata[B_TXERR];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT)      bus_rdata[NSRC-1:0]  = stat_q;
    else if (bus_addr == A_MASK) bus_rdata[NMASK-1:0] = mask_q;
  end

  assign irq      = irq_q;
  assign wptr_rst = wptr_q;

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_w) |=> ((stat_q & $past(set_w)) == $past(set_w)));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_w & ~set_w)) |=> ((stat_q & $past(clr_w & ~set_w)) == '0));

  // R5
  wptr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && bus_wdata[B_TXERR]) |=> wptr_rst);

  // R5
  wptr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_wr && bus_wdata[B_TXERR]) |=> !wptr_rst);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_w == '0) && !ext_w) |=> !irq);

  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_w != '0) || ext_w) |=> irq);
endmodule

// File: rtl/emac_irq_unit.sv
module emac_irq_unit
  import emac_irq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_LEN   = 2032,
  parameter int RETRY_W   = 5,
  parameter int MAX_RETRY = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               rx_pkt_avail,
  input  logic               tx_drained,
  input  logic               rx_overrun,
  input  logic               rx_in_frame,
  input  logic               rx_speed_100,
  input  logic               rx_sym_err,
  input  logic               rx_align_err,
  input  logic               rx_fcs_err,
  input  logic               rx_lenfld_err,
  input  logic               txq_len_valid,
  input  logic [LEN_W-1:0]   txq_len,
  output logic               txq_send,
  output logic               txq_drop,
  input  logic               bo_retry_valid,
  input  logic [RETRY_W-1:0] bo_retry_cnt,
  input  logic               phy_irq,
  input  logic               mgmt_irq,
  output logic               irq,
  output logic               fifo_wptr_rst
);
  logic tx_err_evt;
  logic rx_err_evt;
  src_t set_vec;

  emac_tx_len_check #(
    .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .RETRY_W(RETRY_W), .MAX_RETRY(MAX_RETRY)
  ) u_txchk (
    .clk(clk), .rst_n(rst_n),
    .len_valid(txq_len_valid), .len(txq_len),
    .retry_valid(bo_retry_valid), .retry_cnt(bo_retry_cnt),
    .send(txq_send), .drop(txq_drop), .tx_err_evt(tx_err_evt)
  );

  emac_rx_err_merge u_rxerr (
    .in_frame(rx_in_frame), .speed_100(rx_speed_100), .sym_err(rx_sym_err),
    .align_err(rx_align_err), .fcs_err(rx_fcs_err), .lenfld_err(rx_lenfld_err),
    .rx_err_evt(rx_err_evt)
  );

  always_comb begin
    set_vec.rx_pkt = rx_pkt_avail;
    set_vec.tx_err = tx_err_evt;
    set_vec.tx_emp = tx_drained;
    set_vec.rx_ovf = rx_overrun;
    set_vec.rx_err = rx_err_evt;
  end

  emac_irq_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_OFS(0), .MASK_OFS(4)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .set_vec(set_vec), .phy_irq(phy_irq), .mgmt_irq(mgmt_irq),
    .irq(irq), .wptr_rst(fifo_wptr_rst)
  );

  // R8
  rxerr_sym_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sym_err && !(rx_in_frame && rx_speed_100) && !rx_align_err && !rx_fcs_err
     && !rx_lenfld_err) |-> !rx_err_evt);
endmodule

// File: tb/sim_emac_irq_unit.sv
module sim_emac_irq_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        rx_pkt_avail = 0, tx_drained = 0, rx_overrun = 0;
  logic        rx_in_frame = 0, rx_speed_100 = 0, rx_sym_err = 0;
  logic        rx_align_err = 0, rx_fcs_err = 0, rx_lenfld_err = 0;
  logic        txq_len_valid = 0;
  logic [15:0] txq_len = 0;
  logic        txq_send, txq_drop;
  logic        bo_retry_valid = 0;
  logic [4:0]  bo_retry_cnt = 0;
  logic        phy_irq = 0, mgmt_irq = 0;
  logic        irq, fifo_wptr_rst;

  emac_irq_unit u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 0;

  // reference model state
  int m_stat = 0, m_mask = 'h7F, m_irq = 0, m_wrst = 0;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      summary();
    end
  end

  function automatic int model_read(input int addr);
    if (addr == 0) return m_stat;
    if (addr == 4) return m_mask;
    return 0;
  endfunction

  // one clock with reference-model update and comparison on every cycle
  task automatic cyc();
    int setv, clr, n_stat, n_mask, n_irq, n_wrst, lenbig;
    bit ackw, maskw;
    #1;
    lenbig = (int'(txq_len) > 2032);
    // R6 combinational accept / drop
    check("R6 txq_send", txq_send, txq_len_valid && !lenbig);
    check("R6 txq_drop", txq_drop, txq_len_valid && lenbig);
    setv = 0;
    if (rx_pkt_avail) setv |= 1;
    if ((txq_len_valid && lenbig) || (bo_retry_valid && int'(bo_retry_cnt) > 16)) setv |= 2;
    if (tx_drained) setv |= 4;
    if (rx_overrun) setv |= 8;
    if ((rx_sym_err && rx_in_frame && rx_speed_100) || rx_align_err || rx_fcs_err || rx_lenfld_err)
      setv |= 16;
    ackw  = bus_sel && bus_wr && bus_addr == 0;
    maskw = bus_sel && bus_wr && bus_addr == 4;
    clr    = ackw ? (bus_wdata & 'h1F) : 0;
    n_stat = (m_stat & ~clr) | setv;
    n_mask = maskw ? (bus_wdata & 'h7F) : m_mask;
    n_irq  = ((m_stat & m_mask & 'h1F) != 0) || (phy_irq && m_mask[6]) || (mgmt_irq && m_mask[5]);
    n_wrst = ackw && bus_wdata[1];
    @(posedge clk);
    m_stat = n_stat; m_mask = n_mask; m_irq = n_irq; m_wrst = n_wrst;
    @(negedge clk);
    check("R1 R3 R10 rdata", bus_rdata, model_read(bus_addr));
    check("R9 irq", irq, m_irq);
    check("R5 fifo_wptr_rst", fifo_wptr_rst, m_wrst);
    tx_drained = 0; rx_overrun = 0; rx_sym_err = 0; rx_align_err = 0;
    rx_fcs_err = 0; rx_lenfld_err = 0; txq_len_valid = 0; bo_retry_valid = 0;
  endtask

  task automatic bwrite(input int addr, input int data);
    bus_sel = 1; bus_wr = 1; bus_addr = 12'(addr); bus_wdata = data;
    cyc();
    bus_sel = 0; bus_wr = 0; bus_addr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2 reset values
    bus_addr = 0; #1; check("R2 status reset", bus_rdata, 0);
    bus_addr = 4; #1; check("R2 mask reset", bus_rdata, 'h7F);
    check("R9 irq reset", irq, 0);
    rst_n = 1;
    bus_addr = 0;
    idle(2);

    // R1 each cause individually
    tx_drained = 1; cyc(); check("R1 bit2 drained", bus_rdata, 'h04);
    rx_overrun = 1; cyc(); check("R1 bit3 overrun", bus_rdata, 'h0C);
    rx_fcs_err = 1; cyc(); check("R8 fcs sets bit4", bus_rdata, 'h1C);
    idle(2);
    bwrite(0, 'h1F);               // R3 clear all, R5 pulse
    check("R5 pulse after ack", fifo_wptr_rst, 1);
    cyc(); check("R5 pulse one cycle", fifo_wptr_rst, 0);
    check("R3 cleared", bus_rdata, 0);

    // R8 symbol error gating
    rx_sym_err = 1; cyc(); check("R8 sym outside frame", bus_rdata, 0);
    rx_in_frame = 1; rx_sym_err = 1; cyc(); check("R8 sym at 10M", bus_rdata, 0);
    rx_speed_100 = 1; rx_sym_err = 1; cyc(); check("R8 sym in frame 100M", bus_rdata, 'h10);
    rx_in_frame = 0;
    rx_align_err = 1; cyc();
    rx_lenfld_err = 1; cyc(); check("R8 align/len", bus_rdata, 'h10);
    bwrite(0, 'h00);               // R3 zero write no effect
    check("R3 write zero keeps", bus_rdata, 'h10);
    check("R5 no pulse on zero", fifo_wptr_rst, 0);
    bwrite(0, 'h10); cyc();

    // R6 length boundary
    txq_len_valid = 1; txq_len = 2032; cyc(); check("R6 len 2032 no error", bus_rdata, 0);
    txq_len_valid = 1; txq_len = 2033; cyc(); check("R6 len 2033 error", bus_rdata, 'h02);
    bwrite(0, 'h02); cyc();
    txq_len_valid = 1; txq_len = 16'hFFFF; cyc(); check("R6 len max error", bus_rdata, 'h02);
    bwrite(0, 'h02); cyc();

    // R7 retry limit
    bo_retry_valid = 1; bo_retry_cnt = 16; cyc(); check("R7 retry 16", bus_rdata, 0);
    bo_retry_valid = 1; bo_retry_cnt = 17; cyc(); check("R7 retry 17", bus_rdata, 'h02);
    bo_retry_cnt = 31; cyc(); check("R7 count without valid", bus_rdata, 'h02);

    // R4 set wins against ack in same cycle
    tx_drained = 1; bwrite(0, 'h06);
    check("R4 set wins", bus_rdata, 'h04);
    bwrite(0, 'h04); cyc();

    // R11 packet-received level
    rx_pkt_avail = 1; cyc(); check("R11 pkt set", bus_rdata, 'h01);
    bwrite(0, 'h01); check("R11 ack while stored", bus_rdata, 'h01);
    rx_pkt_avail = 0; bwrite(0, 'h01); cyc(); check("R11 cleared after drain", bus_rdata, 0);

    // R10 mask access, reserved bits
    bwrite(4, 'hFFFFFF80); bus_addr = 4; cyc(); check("R10 mask reserved", bus_rdata, 0);
    bus_addr = 8; cyc(); check("R10 other offset", bus_rdata, 0);
    bus_addr = 0;
    // R9 masked sources do not interrupt
    rx_overrun = 1; phy_irq = 1; mgmt_irq = 1; idle(3); check("R9 masked quiet", irq, 0);
    bwrite(4, 'h08); idle(2); check("R9 overrun enabled", irq, 1);
    bwrite(4, 'h40); bwrite(0, 'h08); idle(2); check("R9 phy enabled", irq, 1);
    phy_irq = 0; idle(2); check("R9 phy dropped", irq, 0);
    bwrite(4, 'h20); idle(2); check("R9 mgmt enabled", irq, 1);
    mgmt_irq = 0; bwrite(4, 'h7F); idle(3);
    summary();
  end
endmodule